// File: doc/BRIEF.md
# Streaming IQ Low-Pass FIR

This block low-pass filters a stream of complex baseband samples. Each accepted sample carries a signed in-phase word and a signed quadrature word. A single set of real, linear-phase coefficients is applied to both rails. The two rails are computed side by side and never mix. The default response has 129 taps, and its odd length gives one centre tap. Only the 65 unique coefficients, from tap 0 up to the centre tap, are held.

The datapath is time-multiplexed, with one multiplier per rail. For every accepted sample the block runs one multiply-accumulate step per clock. Each step adds the two samples that share a coefficient before the multiply. The last step multiplies the centre sample alone. The result is rounded half-up to the output width and clipped to the signed range. It is then presented with a one-cycle strobe.

There is no ready signal, so the producer must space its samples at least 68 clocks apart. A sample offered while a computation is still running is dropped. Data is signed W-bit on both sides, and coefficients are signed with C−1 fraction bits.

Top module: `iq_fir_lowpass`

## Requirements
- R1: A sample is accepted on a rising clock edge where in_valid is high and no computation is in progress. For each accepted sample, out_valid is high for exactly one cycle, beginning 68 clock edges after the accepting edge (HALF+3, where HALF=(TAPS+1)/2).
- R2: Any in_valid seen on the 67 clock edges that follow an accepting edge is ignored. Such a sample does not enter the delay line and produces no output strobe. Later outputs are the same as if it had never been offered.
- R3: A unit-type impulse on one rail, followed by zeros, produces its largest-magnitude output 64 accepted samples later, which is (TAPS−1)/2. The impulse's own output counts as index 0.
- R4: Output n on each rail is y[n] = sat(floor((Σ_j h[j]·x[n−j] + 2^(C−2)) / 2^(C−1))). The sum runs over j = 0..128, with x = 0 before reset history. For tap m = min(j, 128−j) < 64, h[j] = floor((m+1)·2^(C−1)/65²). The centre tap h[64] = 2^(C−1) − 2·Σ_{m<64} h[m]. With C=18 this gives h[0]=31, h[1]=62 and h[64]=2070.
- R5: Both rails use the same coefficients and are independent. A rail whose input is held at zero outputs exactly zero, whatever the other rail carries.
- R6: The coefficients sum to 2^(C−1), so the DC gain is one. After 129 samples of a constant input, each rail outputs that constant exactly, including the extremes +32767 and −32768.
- R7: A synchronous rst clears the delay line, the accumulators, the sequencer, out_valid, out_i and out_q, even in the middle of a computation. The outputs that follow reflect an all-zero history.
- R8: Rounding is half-up. An exact half rounds toward +∞. An impulse of −32768 gives −15 on its lag-1 output (−15.5 exactly), not −16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_i | input | W (16) | Signed in-phase sample |
| in_q | input | W (16) | Signed quadrature sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_i | output | W (16) | Filtered in-phase result |
| out_q | output | W (16) | Filtered quadrature result |

## Verification
The assertions take for granted that no sample is accepted closer than 68 edges to the one before it. They also assume that the coefficient set never drives the accumulator past the signed range of ACC_W bits. The bench offers samples every 70 clocks, so every accepted sample is checked against the spacing rule. Its extra in_valid pulses fall only inside the busy window, where the design must drop them. The same data then passes through a reference model that does not see the dropped pulses. Resets are applied between vector streams and once in the middle of a computation.

// File: rtl/iqlp_pkg.sv
package iqlp_pkg;
  // Triangular low-pass default: side taps floor((m+1)*2^(cw-1)/half^2),
  // centre absorbs the remainder so the full set sums to exactly 2^(cw-1).
  function automatic longint tap_coef(input int k, input int taps, input int cw);
    longint half, one, s;
    half = longint'((taps + 1) / 2);
    one  = longint'(1) << (cw - 1);
    if (longint'(k) < half - 1)
      return ((longint'(k) + 1) * one) / (half * half);
    s = 0;
    for (int j = 0; j < half - 1; j++)
      s += ((longint'(j) + 1) * one) / (half * half);
    return one - 2 * s;
  endfunction
endpackage

// File: rtl/iqlp_seq.sv
module iqlp_seq #(
  parameter int TAPS = 129
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic accept,
  output logic issue,
  output logic [$clog2((TAPS+1)/2)-1:0] k_idx,
  output logic s2_v,
  output logic s2_first,
  output logic done
);
  localparam int HALF    = (TAPS + 1) / 2;
  localparam int SPACING = HALF + 3;
  localparam int KW      = $clog2(HALF);
  localparam int CNT_W   = $clog2(SPACING + 2);

  logic             busy;
  logic [CNT_W-1:0] cyc;
  logic             s1_v, s1_first, s1_last, s2_last;

  assign accept = in_valid && !busy;
  assign issue  = busy && (cyc < CNT_W'(HALF));
  assign k_idx  = KW'(cyc);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; cyc <= '0;
      s1_v <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0;
      s2_v <= 1'b0; s2_first <= 1'b0; s2_last <= 1'b0;
      done <= 1'b0;
    end else begin
      if (accept) begin
        busy <= 1'b1;
        cyc  <= '0;
      end else if (busy) begin
        cyc <= cyc + 1'b1;
        if (cyc == CNT_W'(SPACING - 2)) busy <= 1'b0;
      end
      s1_v     <= issue;
      s1_first <= issue && (cyc == '0);
      s1_last  <= issue && (cyc == CNT_W'(HALF - 1));
      s2_v     <= s1_v;
      s2_first <= s1_first;
      s2_last  <= s1_last;
      done     <= s2_v && s2_last;
    end
  end

  // Independent gap counter for the spacing check
  logic [CNT_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst)                         gap <= CNT_W'(SPACING);
    else if (accept)                 gap <= CNT_W'(1);
    else if (gap < CNT_W'(SPACING))  gap <= gap + 1'b1;
  end

  // R2
  accept_gap_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> gap >= CNT_W'(SPACING));
endmodule

// File: rtl/iqlp_coef.sv
module iqlp_coef #(
  parameter int TAPS = 129,
  parameter int C    = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic [$clog2((TAPS+1)/2)-1:0] k_idx,
  output logic signed [C-1:0] coef
);
  localparam int HALF = (TAPS + 1) / 2;
  localparam int KW   = $clog2(HALF);

  logic signed [C-1:0] tbl [HALF];

  for (genvar g = 0; g < HALF; g++) begin : g_tap
    localparam logic signed [C-1:0] VAL = C'(iqlp_pkg::tap_coef(g, TAPS, C));
    assign tbl[g] = VAL;
  end

  always_ff @(posedge clk) begin
    if (rst)        coef <= '0;
    else if (issue) coef <= tbl[k_idx];
  end

  // R4
  coef_index_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> k_idx < KW'(HALF));
endmodule

// File: rtl/iqlp_rail.sv
module iqlp_rail #(
  parameter int TAPS  = 129,
  parameter int W     = 16,
  parameter int C     = 18,
  parameter int ACC_W = 42
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic signed [W-1:0] sample,
  input  logic issue,
  input  logic [$clog2((TAPS+1)/2)-1:0] k_idx,
  input  logic signed [C-1:0] coef,
  input  logic s2_v,
  input  logic s2_first,
  input  logic done,
  output logic signed [W-1:0] y
);
  localparam int HALF = (TAPS + 1) / 2;
  localparam int KW   = $clog2(HALF);
  localparam int IW   = $clog2(TAPS);
  localparam int PW   = W + 1 + C;
  localparam logic signed [ACC_W-1:0] RND_BIAS = ACC_W'(1) << (C - 2);
  localparam logic signed [ACC_W-1:0] HI = (ACC_W'(1) << (W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] LO = ~HI;

  logic signed [W-1:0]     dl [TAPS];
  logic        [IW-1:0]    ki, mi;
  logic signed [W:0]       pre_d, pre_r;
  logic signed [PW-1:0]    prod_r;
  logic signed [ACC_W-1:0] prod_ext, acc, rnd, shv;

  assign ki = IW'(k_idx);
  assign mi = IW'(TAPS - 1) - ki;

  always_comb begin
    if (k_idx == KW'(HALF - 1)) pre_d = {dl[ki][W-1], dl[ki]};
    else                        pre_d = {dl[ki][W-1], dl[ki]} + {dl[mi][W-1], dl[mi]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) dl[i] <= '0;
    end else if (accept) begin
      dl[0] <= sample;
      for (int i = 1; i < TAPS; i++) dl[i] <= dl[i-1];
    end
  end

  assign prod_ext = ACC_W'(prod_r);
  assign rnd      = acc + RND_BIAS;
  assign shv      = rnd >>> (C - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_r <= '0; prod_r <= '0; acc <= '0; y <= '0;
    end else begin
      if (issue) pre_r <= pre_d;
      prod_r <= PW'(pre_r) * PW'(coef);
      if (s2_v) acc <= s2_first ? prod_ext : acc + prod_ext;
      if (done) begin
        if (shv > HI)      y <= HI[W-1:0];
        else if (shv < LO) y <= LO[W-1:0];
        else               y <= shv[W-1:0];
      end
    end
  end

  logic signed [ACC_W:0] wide_sum;
  assign wide_sum = {acc[ACC_W-1], acc} + {prod_ext[ACC_W-1], prod_ext};

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (s2_v && !s2_first) |-> wide_sum[ACC_W] == wide_sum[ACC_W-1]);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (y == '0 && acc == '0 && dl[0] == '0));
endmodule

// File: rtl/iq_fir_lowpass.sv
module iq_fir_lowpass #(
  parameter int TAPS  = 129,
  parameter int W     = 16,
  parameter int C     = 18,
  parameter int ACC_W = W + C + 1 + $clog2((TAPS + 1) / 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);
  localparam int HALF    = (TAPS + 1) / 2;
  localparam int KW      = $clog2(HALF);
  localparam int SPACING = HALF + 3;
  localparam int CNT_W   = $clog2(SPACING + 2);

  logic accept, issue, s2_v, s2_first, done;
  logic [KW-1:0] k_idx;
  logic signed [C-1:0] coef;
  logic signed [W-1:0] rail_in  [2];
  logic signed [W-1:0] rail_out [2];

  iqlp_seq #(.TAPS(TAPS)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .accept(accept), .issue(issue),
    .k_idx(k_idx), .s2_v(s2_v), .s2_first(s2_first), .done(done)
  );

  iqlp_coef #(.TAPS(TAPS), .C(C)) u_coef (
    .clk(clk), .rst(rst), .issue(issue), .k_idx(k_idx), .coef(coef)
  );

  assign rail_in[0] = in_i;
  assign rail_in[1] = in_q;

  for (genvar r = 0; r < 2; r++) begin : g_rail
    iqlp_rail #(.TAPS(TAPS), .W(W), .C(C), .ACC_W(ACC_W)) u_rail (
      .clk(clk), .rst(rst), .accept(accept), .sample(rail_in[r]), .issue(issue),
      .k_idx(k_idx), .coef(coef), .s2_v(s2_v), .s2_first(s2_first), .done(done),
      .y(rail_out[r])
    );
  end

  assign out_i = rail_out[0];
  assign out_q = rail_out[1];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= done;
  end

  // Clocks since the last accepted sample, for the latency check
  logic [CNT_W-1:0] since;
  always_ff @(posedge clk) begin
    if (rst || accept)              since <= '0;
    else if (since <= CNT_W'(SPACING)) since <= since + 1'b1;
  end

  // R1
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> since == CNT_W'(SPACING - 1));

  // R1
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

// File: tb/tb_iq_fir_lowpass.sv
module tb_iq_fir_lowpass;
  localparam int  TAPS = 129, W = 16, C = 18;
  localparam int  HALF = (TAPS + 1) / 2, SPACING = HALF + 3;
  localparam longint ONE = longint'(1) << (C - 1);

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [W-1:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [W-1:0] out_i, out_q;

  iq_fir_lowpass dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i),
    .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  longint hist_i [TAPS], hist_q [TAPS];
  longint exp_i, exp_q, last_i, last_q;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint bcoef(input int j);
    int m; longint s;
    m = (j < HALF) ? j : TAPS - 1 - j;
    if (m < HALF - 1) return ((longint'(m) + 1) * ONE) / (HALF * HALF);
    s = 0;
    for (int t = 0; t < HALF - 1; t++) s += ((longint'(t) + 1) * ONE) / (HALF * HALF);
    return ONE - 2 * s;
  endfunction

  function automatic longint fold(input longint s);
    longint y;
    y = (s + (ONE >>> 1)) >>> (C - 1);
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  task automatic model_clear();
    for (int j = 0; j < TAPS; j++) begin hist_i[j] = 0; hist_q[j] = 0; end
  endtask

  task automatic model_push(input longint xi, input longint xq);
    longint si, sq;
    for (int j = TAPS - 1; j > 0; j--) begin hist_i[j] = hist_i[j-1]; hist_q[j] = hist_q[j-1]; end
    hist_i[0] = xi; hist_q[0] = xq;
    si = 0; sq = 0;
    for (int j = 0; j < TAPS; j++) begin si += bcoef(j) * hist_i[j]; sq += bcoef(j) * hist_q[j]; end
    exp_i = fold(si); exp_q = fold(sq);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  // Offers one sample, optionally a dropped extra pulse at offset g, and
  // checks the strobe timing and both rails against the model.
  task automatic push(input longint xi, input longint xq, input int g, input string tag);
    bit ok;
    ok = 1'b1;
    @(negedge clk);
    if (out_valid) ok = 1'b0;
    in_valid = 1'b1; in_i = W'(xi); in_q = W'(xq);
    model_push(xi, xq);
    for (int c = 1; c <= SPACING + 1; c++) begin
      @(negedge clk);
      if (c <= SPACING) begin
        if (out_valid) ok = 1'b0;
      end else begin
        if (!out_valid) ok = 1'b0;
        last_i = longint'(out_i); last_q = longint'(out_q);
      end
      if (c == g) begin in_valid = 1'b1; in_i = 16'sh7fff; in_q = -16'sh7fff; end
      else in_valid = 1'b0;
    end
    check(ok, (g != 0) ? "R2 strobe" : "R1 strobe", longint'(ok), 1);
    check(last_i == exp_i, {tag, " out_i"}, last_i, exp_i);
    check(last_q == exp_q, {tag, " out_q"}, last_q, exp_q);
  endtask

  localparam int NV = 5;
  localparam bit     KIND [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0}; // 0 impulse, 1 step
  localparam longint AI   [NV] = '{20000, 0, 32767, -1234, 16384};
  localparam longint AQ   [NV] = '{0, -32768, -32768, 777, -16384};
  localparam int     LEN  [NV] = '{130, 130, 132, 132, 130};
  localparam int     PEAK [NV] = '{64, 64, 0, 0, 64};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint xi, xq, pki, pkq, mqi, mqq;
    int ixi, ixq, seed;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(!out_valid && out_i == 0 && out_q == 0, "R7 reset state",
          longint'(out_valid), 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      pki = 0; pkq = 0; ixi = -1; ixq = -1; mqi = 0; mqq = 0;
      for (int n = 0; n < LEN[v]; n++) begin
        xi = (KIND[v] || n == 0) ? AI[v] : 0;
        xq = (KIND[v] || n == 0) ? AQ[v] : 0;
        push(xi, xq, 0, "R4");
        if ((last_i < 0 ? -last_i : last_i) > pki) begin pki = (last_i < 0 ? -last_i : last_i); ixi = n; end
        if ((last_q < 0 ? -last_q : last_q) > pkq) begin pkq = (last_q < 0 ? -last_q : last_q); ixq = n; end
        if (AI[v] == 0 && last_i != 0) mqi = last_i;
        if (AQ[v] == 0 && last_q != 0) mqq = last_q;
        if (v == 1 && n == 1) check(last_q == -15, "R8 half-up lag1", last_q, -15);
      end
      if (!KIND[v]) begin
        if (AI[v] != 0) check(ixi == PEAK[v], "R3 peak out_i", ixi, PEAK[v]);
        if (AQ[v] != 0) check(ixq == PEAK[v], "R3 peak out_q", ixq, PEAK[v]);
      end else begin
        check(last_i == AI[v], "R6 dc out_i", last_i, AI[v]);
        check(last_q == AQ[v], "R6 dc out_q", last_q, AQ[v]);
      end
      if (AI[v] == 0) check(mqi == 0, "R5 idle out_i", mqi, 0);
      if (AQ[v] == 0) check(mqq == 0, "R5 idle out_q", mqq, 0);
    end

    // R2: mixed stream with dropped pulses inside the busy window
    do_reset();
    seed = 7;
    for (int n = 0; n < 40; n++) begin
      seed = seed * 1103515245 + 12345;
      xi = longint'($signed(seed[23:8]));
      seed = seed * 1103515245 + 12345;
      xq = longint'($signed(seed[23:8]));
      push(xi, xq, (n == 5) ? 1 : (n == 10) ? SPACING - 1 : (n == 20) ? 33 : 0,
           (n == 5 || n == 10 || n == 20) ? "R2" : "R4");
    end

    // R7: reset in the middle of a computation
    @(negedge clk); in_valid = 1'b1; in_i = 16'sh1234; in_q = -16'sh0321;
    @(negedge clk); in_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    check(!out_valid && out_i == 0 && out_q == 0, "R7 mid reset", longint'(out_i), 0);
    push(32767, -32768, 0, "R7");
    check(last_i == 8 && last_q == -8, "R7 fresh history", last_i, 8);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule